// File: doc/BRIEF.md
# Interrupt Controller with Tick Counter

This block gathers interrupt requests from three sources (serial receive data available, a periodic timer tick, and an audio channel) and presents them to a simple CPU through one 32-bit memory-mapped register. Each request line sets a sticky pending flag. While the global delivery enable is set, any pending flag raises a single-cycle request to the CPU.

The same register also carries a free-running count of timer ticks since reset. Software reads the register to find which sources need service. It writes the register to set or clear the delivery enable, and any write clears all pending flags. The enable clears itself when an interrupt is delivered, so the service routine must write the enable bit again before it returns. After each such write, delivery is held off for a fixed number of clocks so that the CPU can finish its return from the interrupt.

Top module: `irq_controller`

## Requirements
- R1: After reset (asynchronous assertion of `rst_n`, then two clocks after release for synchronisation), every pending flag is 0, the tick count is 0, delivery is disabled and `irq_out` is 0.
- R2: A read (`cs` and `rd_en` both high) returns the tick count in bits 31:8, zero in bits 7:3, and the pending flags in bits 2:0, where bit 0 is serial receive, bit 1 is timer tick and bit 2 is audio. `rd_data` is all zeros when no read is selected.
- R3: A request line that is high at a clock edge with no register write sets its pending flag. The flag stays set until the next register write.
- R4: Any register write (`cs` and `wr_en` both high) clears all pending flags at that edge, whatever the request lines are doing. A line that is still high sets its flag again at the following edge.
- R5: The tick count rises by one at each clock edge where request line 1 is high, and wraps modulo 2^TICK_W (2^24 by default).
- R6: A write with `wr_data[7]` = 1 arms delivery. A write with `wr_data[7]` = 0 disarms it, and while it is disarmed `irq_out` stays 0 even with flags pending.
- R7: When delivery is armed, the hold-off has elapsed and at least one flag is pending, `irq_out` goes high for exactly one clock. Delivery disarms itself at that same edge, so no further pulse comes until the enable is written again. Pending flags are not cleared by delivery.
- R8: After an arming write at edge E, `irq_out` stays low through edge E+ARM_DELAY (15 by default). With a flag already pending it rises at edge E+ARM_DELAY+1. A flag that arrives after the hold-off produces `irq_out` one edge after the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_in | input | 3 | Request lines: 0 serial receive, 1 timer tick, 2 audio |
| cs | input | 1 | Register select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data; bit 7 is the delivery enable |
| rd_data | output | 32 | Read data: tick count, zero padding, pending flags |
| irq_out | output | 1 | Single-cycle interrupt request to the CPU |

## Verification
The hardest situation to reach is the boundary of the hold-off window. Delivery must stay quiet for exactly ARM_DELAY edges after an arming write and then fire on the next edge. The stimulus reaches this by setting a flag in the cycle right after the arming write and sampling `irq_out` on every edge up to and past the window. A second run arms delivery first and brings the request in only after the window has closed. The tick wrap would take 2^24 ticks at the default width, so a second instance with an 8-bit tick field is driven through 256 ticks to reach it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned LINE_SERIAL = 0;
  localparam int unsigned LINE_TICK   = 1;
  localparam int unsigned LINE_AUDIO  = 2;
  localparam int unsigned NUM_LINES   = 3;
  localparam int unsigned ENABLE_BIT  = 7;

  typedef enum logic [1:0] {
    ARM_OFF  = 2'd0,
    ARM_HOLD = 2'd1,
    ARM_LIVE = 2'd2
  } arm_state_t;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int unsigned LINES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_in,
  input  logic             clear,
  output logic [LINES-1:0] pend
);
  logic [LINES-1:0] pend_q;
  logic [LINES-1:0] pend_d;

  always_comb begin
    if (clear) pend_d = '0;
    else       pend_d = pend_q | req_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R4: a write empties every flag at its edge
  assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pend_q == '0));

  // R3: without a write no flag drops
  assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/irqc_tick_counter.sv
module irqc_tick_counter #(
  parameter int unsigned TICK_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  output logic [TICK_W-1:0] count
);
  logic [TICK_W-1:0] cnt_q;
  logic [TICK_W-1:0] cnt_d;

  always_comb begin
    if (tick_in) cnt_d = cnt_q + 1'b1;
    else         cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R5: one step per tick, modulo the counter width
  assert_tick_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_in |=> (cnt_q == TICK_W'($past(cnt_q) + 1'b1)));

  // R5: no tick, no change
  assert_tick_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_in |=> $stable(cnt_q));
endmodule

// File: rtl/irqc_arm.sv
module irqc_arm
  import irqc_pkg::*;
#(
  parameter int unsigned ARM_DELAY = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_write,
  input  logic enable_bit,
  input  logic any_pending,
  output logic irq
);
  localparam int unsigned CNT_W = ($clog2(ARM_DELAY + 1) > 0) ? $clog2(ARM_DELAY + 1) : 1;
  localparam logic [CNT_W-1:0] DELAY_LOAD = CNT_W'(ARM_DELAY);
  localparam logic [CNT_W-1:0] LAST_HOLD  = CNT_W'(1);

  arm_state_t       state_q, state_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic             irq_q, irq_d;
  logic             deliver;

  assign deliver = (state_q == ARM_LIVE) && any_pending && !bus_write;

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    irq_d   = deliver;
    if (bus_write) begin
      if (enable_bit) begin
        if (ARM_DELAY == 0) begin
          state_d = ARM_LIVE;
          hold_d  = '0;
        end else begin
          state_d = ARM_HOLD;
          hold_d  = DELAY_LOAD;
        end
      end else begin
        state_d = ARM_OFF;
        hold_d  = '0;
      end
    end else begin
      unique case (state_q)
        ARM_HOLD: begin
          if (hold_q == LAST_HOLD) begin
            state_d = ARM_LIVE;
            hold_d  = '0;
          end else begin
            hold_d = hold_q - 1'b1;
          end
        end
        ARM_LIVE: begin
          if (deliver) state_d = ARM_OFF;
        end
        default: begin
          state_d = ARM_OFF;
          hold_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARM_OFF;
      hold_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      irq_q   <= irq_d;
    end
  end

  assign irq = irq_q;

  // R6: disarmed means no request on the next edge
  assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARM_OFF) |=> !irq_q);

  // R8: the hold-off window never delivers
  assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARM_HOLD) |=> !irq_q);

  // R7: the request lasts one clock
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R7: delivery leaves the controller disarmed
  assert_self_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> (state_q == ARM_OFF));
endmodule

// File: rtl/irq_controller.sv
module irq_controller
  import irqc_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TICK_W    = 24,
  parameter int unsigned ARM_DELAY = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_in,
  input  logic                 cs,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 irq_out
);
  localparam int unsigned TICK_LSB = DATA_W - TICK_W;
  localparam int unsigned PAD_W    = TICK_LSB - NUM_LINES;

  logic                 rst_sync_n;
  logic                 bus_write;
  logic                 bus_read;
  logic [NUM_LINES-1:0] pend;
  logic [TICK_W-1:0]    ticks;
  logic [DATA_W-1:0]    status_word;
  logic                 unused_wr_bits;

  assign bus_write      = cs && wr_en;
  assign bus_read       = cs && rd_en;
  assign unused_wr_bits = ^{wr_data[DATA_W-1:ENABLE_BIT+1], wr_data[ENABLE_BIT-1:0]};

  irqc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irqc_pending #(.LINES(NUM_LINES)) u_pending (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .req_in (req_in),
    .clear  (bus_write),
    .pend   (pend)
  );

  irqc_tick_counter #(.TICK_W(TICK_W)) u_ticks (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_in (req_in[LINE_TICK]),
    .count   (ticks)
  );

  irqc_arm #(.ARM_DELAY(ARM_DELAY)) u_arm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bus_write   (bus_write),
    .enable_bit  (wr_data[ENABLE_BIT]),
    .any_pending (|pend),
    .irq         (irq_out)
  );

  assign status_word = {ticks, {PAD_W{1'b0}}, pend};

  always_comb begin
    if (bus_read) rd_data = status_word;
    else          rd_data = '0;
  end

  // R2: the bus stays quiet when no read is selected
  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_read |-> (rd_data == '0));

  // R7: a request to the CPU needs a pending flag before it
  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_out) |-> ($past(pend) != '0));
endmodule

// File: tb/irq_controller_test.sv
module irq_controller_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  req = '0;
  logic        cs = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_out;

  logic [2:0]  req_nw = '0;
  logic        cs_nw = 1'b0, rd_nw = 1'b0;
  logic [15:0] rd_data_nw;
  logic        irq_nw;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_controller uut (
    .clk(clk), .rst_n(rst_n), .req_in(req), .cs(cs), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
  );

  irq_controller #(.DATA_W(16), .TICK_W(8)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .req_in(req_nw), .cs(cs_nw), .rd_en(rd_nw),
    .wr_en(1'b0), .wr_data(16'h0000), .rd_data(rd_data_nw), .irq_out(irq_nw)
  );

  // fields: [6:4] request pattern, [3] write-clear in the same cycle, [2:0] expected flags
  localparam logic [6:0] VEC [8] = '{
    7'b001_0_001,
    7'b100_0_101,
    7'b000_0_101,
    7'b000_1_000,
    7'b010_0_010,
    7'b110_1_000,
    7'b000_0_000,
    7'b111_0_111
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_reg(output logic [31:0] v);
    cs = 1'b1; rd_en = 1'b1;
    #1;
    v = rd_data;
    cs = 1'b0; rd_en = 1'b0;
  endtask

  task automatic bus_write(input logic [31:0] d);
    cs = 1'b1; wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [23:0] exp_tick;
    bit          seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();

    // R1: reset state
    read_reg(v);
    check(v == 32'h0, "R1 reset read", v, 32'h0);
    check(irq_out == 1'b0, "R1 reset irq", {31'b0, irq_out}, 32'h0);
    v = {16'h0, rd_data};
    check(rd_data == 32'h0, "R2 idle bus zero", v, 32'h0);

    // R2 R3 R4 R5: vector table walk
    exp_tick = '0;
    for (int i = 0; i < 8; i++) begin
      req = VEC[i][6:4];
      cs = VEC[i][3]; wr_en = VEC[i][3]; wr_data = '0;
      @(posedge clk);
      if (VEC[i][5]) exp_tick = exp_tick + 1'b1;
      @(negedge clk);
      req = '0; cs = 1'b0; wr_en = 1'b0;
      read_reg(v);
      check(v == {exp_tick, 5'b0, VEC[i][2:0]}, "R3 R4 R2 table", v, {exp_tick, 5'b0, VEC[i][2:0]});
      check(irq_out == 1'b0, "R6 disarmed quiet", {31'b0, irq_out}, 32'h0);
    end

    // R4: held line comes back one edge after the clearing write
    req = 3'b001;
    bus_write(32'h0);
    read_reg(v);
    check(v[2:0] == 3'b000, "R4 cleared at write edge", v, {exp_tick, 8'h00});
    step();
    read_reg(v);
    check(v[2:0] == 3'b001, "R4 reasserted next edge", v, {exp_tick, 8'h01});
    req = '0;

    // R8 R7: arm, flag pending right after, watch the window
    bus_write(32'h80);          // arming edge E0
    req = 3'b100;
    step();                     // E1
    req = '0;
    check(irq_out == 1'b0, "R8 quiet at E1", {31'b0, irq_out}, 32'h0);
    for (int k = 2; k <= 20; k++) begin
      step();
      check(irq_out == (k == 16), "R8 R7 window edge", {31'b0, irq_out}, {31'b0, k == 16});
    end
    read_reg(v);
    check(v[2:0] == 3'b100, "R7 delivery keeps flags", v, {exp_tick, 8'h04});

    // R6: disarm before the window ends, keep a flag pending
    bus_write(32'h80);
    bus_write(32'h00);
    req = 3'b100;
    step();
    req = '0;
    seen = 1'b0;
    for (int k = 0; k < 24; k++) begin
      step();
      if (irq_out) seen = 1'b1;
    end
    check(!seen, "R6 disarmed with flag", {31'b0, seen}, 32'h0);

    // R8: flag arrives after the window closes
    bus_write(32'h80);
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      step();
      if (irq_out) seen = 1'b1;
    end
    check(!seen, "R8 armed no flag", {31'b0, seen}, 32'h0);
    req = 3'b001;
    step();                     // flag set
    req = '0;
    check(irq_out == 1'b0, "R8 not yet", {31'b0, irq_out}, 32'h0);
    step();
    check(irq_out == 1'b1, "R8 late flag fires", {31'b0, irq_out}, 32'h1);
    step();
    check(irq_out == 1'b0, "R7 one clock", {31'b0, irq_out}, 32'h0);

    // R5: wrap on the narrow instance
    req_nw = 3'b010;
    repeat (255) @(posedge clk);
    @(negedge clk);
    req_nw = '0;
    cs_nw = 1'b1; rd_nw = 1'b1; #1;
    check(rd_data_nw[15:8] == 8'd255, "R5 count to max", {16'h0, rd_data_nw}, 32'h0000FF00);
    cs_nw = 1'b0; rd_nw = 1'b0;
    req_nw = 3'b010;
    step();
    req_nw = '0;
    cs_nw = 1'b1; rd_nw = 1'b1; #1;
    check(rd_data_nw[15:8] == 8'd0, "R5 wrap to zero", {16'h0, rd_data_nw}, 32'h00000002);
    check(rd_data_nw[2:0] == 3'b010, "R3 narrow tick flag", {16'h0, rd_data_nw}, 32'h00000002);
    cs_nw = 1'b0; rd_nw = 1'b0;

    // R1: reset in the middle of a run
    req = 3'b111;
    step();
    req = '0;
    rst_n = 1'b0;
    #1;
    check(irq_out == 1'b0, "R1 async reset irq", {31'b0, irq_out}, 32'h0);
    repeat (2) step();
    rst_n = 1'b1;
    repeat (3) step();
    read_reg(v);
    check(v == 32'h0, "R1 reset clears count and flags", v, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule